// File: doc/BRIEF.md
# I2C Register Target with Deferred Nonvolatile Commit

This block is the I2C slave front end of a small register file in which every live register has a nonvolatile twin. The raw SCL and SDA lines are brought into the system clock domain. The block detects START, repeated START and STOP, and answers one 7-bit device address. It accepts register writes and serves register reads, and it drives SDA through an open-drain style enable.

A written byte reaches the live register during the acknowledge of that byte, so downstream logic sees the new setting at once. The nonvolatile copy is only touched when the write transaction is closed by STOP. The block then pulses a commit request, and the external store answers with a busy level while it programs. A master that ends its write with a repeated START changes only the live setting. At reset the live registers reload from the image that the store presents.

Top module: `nvi2c_target`

## Requirements
- R1: The device answers the 7-bit address {DEV_BASE, addr_sel} with DEV_BASE = 5'b01010. With addr_sel = 0 this gives the write byte 0x50 and the read byte 0x51. Bit 0 of the first byte after START selects write (0) or read (1), and the device acknowledges by pulling SDA low during the ninth clock.
- R2: On any other address the device does not acknowledge. It then ignores every later byte, with no register change and no commit, until the next START.
- R3: In a write, the byte after the address byte sets the register pointer (its low log2(NREG) bits), and every further byte is data. The addressed live register holds the new data byte before the acknowledge clock of that byte ends.
- R4: The register pointer advances by one after each data byte written or read, and steps from NREG-1 back to 0.
- R5: A transaction that has written at least one data byte and ends in STOP produces exactly one single-cycle pulse on nv_commit_o, with nv_image_o holding the live registers. A transaction without data bytes produces none.
- R6: A write ended by a repeated START produces no commit, and the nonvolatile image keeps its old value.
- R7: Read data starts at the register pointer and goes out MSB first. Another byte follows each master ACK. After a master NACK the device releases SDA and goes idle.
- R8: While nv_busy_i is high the device does not acknowledge its own address.
- R9: While rst is high, the live registers load from nv_image_i and SDA is released.
- R10: The device changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Address pin levels, low address bits |
| nv_image_i | input | NREG*8 | Stored nonvolatile image, register r at bits r*8+7:r*8 |
| nv_busy_i | input | 1 | Nonvolatile store is programming |
| nv_commit_o | output | 1 | One-cycle request to store nv_image_o |
| nv_image_o | output | NREG*8 | Image to be stored on commit |
| live_o | output | NREG*8 | Live register outputs |

## Verification
The live write and the commit decision can land in the same cycle. A data byte is written into a live register during its acknowledge, and an end-of-transaction condition can follow directly on the next SCL high. The bench provokes this by closing a multi-byte write with a repeated START straight after the last data acknowledge, and also by closing a single-byte write with STOP. It judges the first case by reading the registers back and finding the new values while the bench's own store model is unchanged. It judges the second case by a single commit whose captured image matches the expected registers. A further case sends the device's address right after a committing STOP, while the store is still busy, and expects a NACK.

// File: rtl/nvi2c_pkg.sv
package nvi2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_REG,
        ROLE_DATA
    } byte_role_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic dev_match(input logic [7:0] b,
                                       input logic [4:0] base,
                                       input logic [1:0] sel);
        return b[7:1] == {base, sel};
    endfunction

endpackage

// File: rtl/nvi2c_sync.sv
module nvi2c_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_s,
    output nvi2c_pkg::bus_evt_t evt
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_pipe;
    logic [MSB:0] sda_pipe;
    logic         scl_q;
    logic         sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
            scl_q    <= scl_pipe[MSB];
            sda_q    <= sda_pipe[MSB];
        end
    end

    assign scl_s        = scl_pipe[MSB];
    assign evt.sda      = sda_pipe[MSB];
    assign evt.scl_rise = scl_pipe[MSB] & ~scl_q;
    assign evt.scl_fall = ~scl_pipe[MSB] & scl_q;
    assign evt.start    = scl_pipe[MSB] & scl_q & sda_q & ~sda_pipe[MSB];
    assign evt.stop     = scl_pipe[MSB] & scl_q & ~sda_q & sda_pipe[MSB];

endmodule

// File: rtl/nvi2c_regbank.sv
module nvi2c_regbank #(
    parameter int NREG = 4,
    parameter int PW   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREG*8-1:0] nv_image_i,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_ptr,
    input  logic [7:0]        wr_data,
    input  logic [PW-1:0]     rd_ptr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] live_flat
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= nv_image_i[g*8 +: 8];
            end else if (wr_en && (wr_ptr == PW'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign live_flat[g*8 +: 8] = regs[g];
    end

    assign rd_data = regs[rd_ptr];

endmodule

// File: rtl/nvi2c_link.sv
module nvi2c_link
    import nvi2c_pkg::*;
#(
    parameter int         NREG     = 4,
    parameter int         PW       = 2,
    parameter logic [4:0] DEV_BASE = 5'b01010
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [1:0]    addr_sel,
    input  logic          nv_busy_i,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [7:0]    wr_data,
    output logic [PW-1:0] ptr,
    output logic          commit,
    output logic          addr_ack
);
    link_state_e state;
    byte_role_e  role;
    logic [3:0]  cnt;
    logic [7:0]  sh;
    logic [7:0]  tx;
    logic        rw;
    logic        wrote;
    logic [PW-1:0] ptr_next;

    assign ptr_next = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        wr_en    <= 1'b0;
        commit   <= 1'b0;
        addr_ack <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            role    <= ROLE_DEV;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            wrote   <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else if (evt.start) begin
            state  <= ST_RX;
            role   <= ROLE_DEV;
            cnt    <= '0;
            wrote  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            commit <= wrote;
            wrote  <= 1'b0;
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (evt.scl_rise) begin
                        sh  <= {sh[6:0], evt.sda};
                        cnt <= cnt + 4'd1;
                    end else if (evt.scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        case (role)
                            ROLE_DEV: begin
                                if (dev_match(sh, DEV_BASE, addr_sel) && !nv_busy_i) begin
                                    state    <= ST_RX_ACK;
                                    sda_oe   <= 1'b1;
                                    rw       <= sh[0];
                                    addr_ack <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            ROLE_REG: begin
                                ptr    <= sh[PW-1:0];
                                state  <= ST_RX_ACK;
                                sda_oe <= 1'b1;
                            end
                            default: begin
                                wr_en   <= 1'b1;
                                wr_ptr  <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr_next;
                                wrote   <= 1'b1;
                                state   <= ST_RX_ACK;
                                sda_oe  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (evt.scl_fall) begin
                        if (role == ROLE_DEV && rw) begin
                            state  <= ST_TX;
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr_next;
                            cnt    <= '0;
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            role   <= (role == ROLE_DEV) ? ROLE_REG : ROLE_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (evt.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                            cnt    <= '0;
                        end else begin
                            cnt    <= cnt + 4'd1;
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (evt.scl_rise) begin
                        state <= evt.sda ? ST_IDLE : ST_TX_NEXT;
                    end
                end
                ST_TX_NEXT: begin
                    if (evt.scl_fall) begin
                        state  <= ST_TX;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr_next;
                        cnt    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nvi2c_target.sv
module nvi2c_target
    import nvi2c_pkg::*;
#(
    parameter int         NREG        = 4,
    parameter logic [4:0] DEV_BASE    = 5'b01010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    input  logic [1:0]        addr_sel,
    input  logic [NREG*8-1:0] nv_image_i,
    input  logic              nv_busy_i,
    output logic              nv_commit_o,
    output logic [NREG*8-1:0] nv_image_o,
    output logic [NREG*8-1:0] live_o
);
    localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

    bus_evt_t          bus_evt;
    logic              scl_s;
    logic              stop_det;
    logic              wr_en;
    logic [PW-1:0]     wr_ptr;
    logic [7:0]        wr_data;
    logic [PW-1:0]     ptr;
    logic [7:0]        rd_data;
    logic              addr_ack;
    logic [NREG*8-1:0] live_flat;

    nvi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .evt   (bus_evt)
    );

    nvi2c_link #(.NREG(NREG), .PW(PW), .DEV_BASE(DEV_BASE)) u_link (
        .clk       (clk),
        .rst       (rst),
        .evt       (bus_evt),
        .addr_sel  (addr_sel),
        .nv_busy_i (nv_busy_i),
        .rd_data   (rd_data),
        .sda_oe    (sda_drive_low),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .commit    (nv_commit_o),
        .addr_ack  (addr_ack)
    );

    nvi2c_regbank #(.NREG(NREG), .PW(PW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .nv_image_i (nv_image_i),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .wr_data    (wr_data),
        .rd_ptr     (ptr),
        .rd_data    (rd_data),
        .live_flat  (live_flat)
    );

    assign stop_det   = bus_evt.stop;
    assign live_o     = live_flat;
    assign nv_image_o = live_flat;

endmodule

// File: rtl/nvi2c_checker.sv
module nvi2c_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         scl_s,
    input logic         stop_det,
    input logic         nv_commit_o,
    input logic         nv_busy_i,
    input logic         sda_drive_low,
    input logic         wr_en,
    input logic         addr_ack,
    input logic [W-1:0] live_o
);
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        nv_commit_o |=> !nv_commit_o);                                   // R5

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        nv_commit_o |-> $past(stop_det));                                // R5

    AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        nv_commit_o |-> !nv_busy_i);                                     // R8

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        addr_ack |-> !$past(nv_busy_i));                                 // R8

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(live_o));                                     // R3

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_s);                             // R10

endmodule

bind nvi2c_target nvi2c_checker #(.W(NREG*8)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (scl_s),
    .stop_det      (stop_det),
    .nv_commit_o   (nv_commit_o),
    .nv_busy_i     (nv_busy_i),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .addr_ack      (addr_ack),
    .live_o        (live_o)
);

// File: tb/nvi2c_target_bench.sv
module nvi2c_target_bench;
    localparam int NREG     = 4;
    localparam int Q        = 8;
    localparam int BUSY_CYC = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic [31:0] nv_mem = 32'hC3A5_5A3C;
    int          busy_cnt = 0;
    int          commit_cnt = 0;
    logic        nv_busy;
    logic        sda_drive_low;
    logic        nv_commit;
    logic [31:0] nv_image_o;
    logic [31:0] live_o;
    logic        sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    int r10_viol = 0;
    logic [31:0] exp_live;
    logic [31:0] exp_nv;

    assign sda_line = m_sda & ~sda_drive_low;
    assign nv_busy  = (busy_cnt != 0);

    nvi2c_target u_nvi2c_target (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (m_scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .addr_sel      (addr_sel),
        .nv_image_i    (nv_mem),
        .nv_busy_i     (nv_busy),
        .nv_commit_o   (nv_commit),
        .nv_image_o    (nv_image_o),
        .live_o        (live_o)
    );

    // store model: capture on request, then busy for a fixed time
    always @(posedge clk) begin
        if (nv_commit) begin
            nv_mem     <= nv_image_o;
            busy_cnt   <= BUSY_CYC;
            commit_cnt <= commit_cnt + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    // R10 monitor: drive may only change while raw SCL is low
    logic prev_drive = 1'b0;
    always @(posedge clk) begin
        if (!rst && m_scl && (sda_drive_low != prev_drive)) r10_viol++;
        prev_drive <= sda_drive_low;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_sda = ~mack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic wait_idle_store();
        while (nv_busy) tick(1);
        tick(2);
    endtask

    function automatic logic [7:0] byte_of(input logic [31:0] v, input int r);
        return v[r*8 +: 8];
    endfunction

    task automatic finish_run();
        chk("R10", r10_viol, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         cbase;

        exp_nv   = 32'hC3A5_5A3C;
        exp_live = exp_nv;
        tick(5);
        chk("R9 live load", live_o, exp_nv);
        chk("R9 sda released", {31'd0, sda_drive_low}, 32'd0);
        rst = 1'b0;
        tick(5);

        // R1 / R2: full address sweep with addr_sel = 0
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, ack);
            bus_stop();
            chk("R1 ack vs address", {31'd0, ack}, {31'd0, (a[6:0] == 7'h28)});
        end
        // R1: pins select the low address bits
        for (int s = 1; s < 4; s++) begin
            addr_sel = s[1:0];
            tick(4);
            for (int c = 0; c < 4; c++) begin
                bus_start();
                send_byte({5'b01010, c[1:0], 1'b0}, ack);
                bus_stop();
                chk("R1 pin select", {31'd0, ack}, {31'd0, (c == s)});
            end
        end
        addr_sel = 2'd0;
        tick(4);
        chk("R5 no commit without data", commit_cnt, 0);

        // R3 / R5: single-byte write into every register, closed by STOP
        for (int r = 0; r < NREG; r++) begin
            logic [7:0] v;
            v = 8'h5B ^ (8'h27 * (r + 1));
            cbase = commit_cnt;
            bus_start();
            send_byte(8'h50, ack);
            send_byte(r[7:0], ack);
            send_byte(v, ack);
            chk("R3 data ack", {31'd0, ack}, 32'd1);
            exp_live[r*8 +: 8] = v;
            chk("R3 live after ack", {24'd0, byte_of(live_o, r)}, {24'd0, v});
            chk("R5 store untouched before STOP", nv_mem, exp_nv);
            bus_stop();
            tick(4);
            exp_nv = exp_live;
            chk("R5 one commit", commit_cnt, cbase + 1);
            chk("R5 stored image", nv_mem, exp_nv);
            if (r == 0) begin
                // R8: own address refused while the store is busy
                bus_start();
                send_byte(8'h50, ack);
                bus_stop();
                chk("R8 nack while busy", {31'd0, ack}, 32'd0);
            end
            wait_idle_store();
        end
        // R8: accepted again once the store is idle
        bus_start();
        send_byte(8'h50, ack);
        bus_stop();
        chk("R8 ack after busy", {31'd0, ack}, 32'd1);

        // R4 / R6: wrapping burst write closed by repeated START, then read on
        cbase = commit_cnt;
        bus_start();
        send_byte(8'h50, ack);
        send_byte(8'h03, ack);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'hA0 + k[7:0], ack);
            exp_live[((3 + k) % NREG)*8 +: 8] = 8'hA0 + k[7:0];
        end
        chk("R4 wrapped burst live", live_o, exp_live);
        bus_start();
        send_byte(8'h51, ack);
        recv_byte(1'b0, rb);
        chk("R4 pointer continues after burst", {24'd0, rb}, {24'd0, byte_of(exp_live, 2)});
        bus_stop();
        tick(4);
        chk("R6 no commit on repeated START", commit_cnt, cbase);
        chk("R6 store keeps old image", nv_mem, exp_nv);

        // R7: multi-byte read from register 2 with wrap, NACK on the last
        bus_start();
        send_byte(8'h50, ack);
        send_byte(8'h02, ack);
        bus_start();
        send_byte(8'h51, ack);
        chk("R7 read address ack", {31'd0, ack}, 32'd1);
        for (int k = 0; k < 5; k++) begin
            recv_byte(k != 4, rb);
            chk("R7 read byte", {24'd0, rb}, {24'd0, byte_of(exp_live, (2 + k) % NREG)});
        end
        tick(2);
        chk("R7 released after NACK", {31'd0, sda_drive_low}, 32'd0);
        bus_stop();
        tick(4);
        chk("R7 no commit on read", commit_cnt, cbase);

        // R2: bytes after a wrong address are ignored
        bus_start();
        send_byte(8'h52, ack);
        chk("R2 nack wrong address", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        chk("R2 later byte ignored", {31'd0, ack}, 32'd0);
        send_byte(8'hFF, ack);
        bus_stop();
        tick(4);
        chk("R2 live unchanged", live_o, exp_live);
        chk("R2 no commit", commit_cnt, cbase);

        // R9: reset reloads the committed image, dropping uncommitted values
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        chk("R9 reload after reset", live_o, exp_nv);

        finish_run();
    end

endmodule